// File: doc/BRIEF.md
# Shared-Bit Doorbell Interrupt Mapper

This block folds per-interface completion events into one 16-bit doorbell register and raises a single interrupt line to the host. It handles two kinds of event: "send done" and "receive done". Every interface owns two bits of the register, one for each direction. When there are more interfaces than bit pairs, the pairs are reused. Interfaces whose indices are equal modulo the pair count fold onto the same bits. A set bit therefore names a reason and a group of candidate interfaces, not a single interface.

The host services the line in three steps. It reads the register. It picks a bit and presents that bit's index on a select input, and the block answers with the candidate interface mask and the direction. It then writes ones to the bits it has handled, which clears them. A new event that lands in the same cycle as the clear of its bit is kept, so no completion is lost. The pair count must be a power of two. Events are registered, so a bit and the interrupt line change on the clock edge that samples the event.

Top module: `doorbell_irq_mapper`

## Requirements
- R1: After reset the doorbell register reads 0x0000 and `irq` is low.
- R2: A send event on interface i sets register bit (i mod 8) on the next rising clock edge.
- R3: A receive event on interface i sets register bit 8 + (i mod 8) on the next rising clock edge.
- R4: A set bit stays set until cleared. Interfaces that share a bit all set that same bit, and further events on a set bit change nothing.
- R5: When `clr_we` is high, every bit that is one in `clr_mask` is cleared on the next edge. Bits that are zero in the mask keep their value.
- R6: If an event sets a bit in the same cycle as a clear of that bit, the bit ends up set.
- R7: `irq` is high exactly when the register is nonzero. It stays high until the register returns to zero.
- R8: While `clr_we` is low, `clr_mask` has no effect on the register.
- R9: `sel_bit[3]` gives the direction of the selected bit (1 = receive). Bit i of `cand_if` is high exactly when i mod 8 equals `sel_bit[2:0]`.
- R10: With 32 interfaces, every selected bit lists exactly four candidate interfaces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| send_evt | input | 32 | Per-interface send-completion pulse |
| recv_evt | input | 32 | Per-interface receive-completion pulse |
| clr_we | input | 1 | Host write strobe for write-one-to-clear |
| clr_mask | input | 16 | Bits to clear when `clr_we` is high |
| sel_bit | input | 4 | Register bit index to decode |
| db_bits | output | 16 | Doorbell register contents |
| irq | output | 1 | Master interrupt to the host |
| cand_if | output | 32 | Interfaces that could have set the selected bit |
| cand_is_recv | output | 1 | Selected bit belongs to the receive direction |

## Verification
The assertions assume the following about the inputs:
- Every event and clear input is a clean, synchronous level that is sampled once per edge.
- Nothing is driven during the two cycles in which the internal reset is still being released.

The assertions also take for granted that an interrupt can only fall because of a host clear, which holds only if the event inputs carry no stray pulses. The stimulus follows these rules in three ways:
- It leaves every input at zero through reset and for several cycles after it.
- It changes inputs only half a period away from the sampling edge.
- It mixes random event bursts with clears whose masks it draws so that some collide with new events on the same bit.

// File: rtl/db_pkg.sv
package db_pkg;

  // Direction code carried by the top bit of a register index.
  typedef enum logic {
    DB_DIR_SEND = 1'b0,
    DB_DIR_RECV = 1'b1
  } db_dir_e;

  // Number of interfaces folded onto one bit.
  function automatic int db_share(input int n_if, input int pairs);
    return (n_if + pairs - 1) / pairs;
  endfunction

endpackage

// File: rtl/db_event_fold.sv
module db_event_fold #(
  parameter int N_IF  = 32,
  parameter int PAIRS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IF-1:0]  evt,
  output logic [PAIRS-1:0] hit
);
  localparam int SHARE = db_pkg::db_share(N_IF, PAIRS);

  logic [PAIRS-1:0][SHARE-1:0] part;

  for (genvar b = 0; b < PAIRS; b++) begin : g_bit
    for (genvar j = 0; j < SHARE; j++) begin : g_member
      if (b + j * PAIRS < N_IF) begin : g_live
        assign part[b][j] = evt[b + j * PAIRS];
      end else begin : g_pad
        assign part[b][j] = 1'b0;
      end
    end
    assign hit[b] = |part[b];
  end

  // R2
  fold_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |-> (hit != '0));

  // R4
  fold_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(hit) <= $countones(evt)));

endmodule

// File: rtl/db_w1c_reg.sv
module db_w1c_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] db_q
);
  logic [W-1:0] db_d;
  logic [W-1:0] clr_eff;
  logic         upd_en;

  always_comb begin
    clr_eff = clr_we ? clr_mask : '0;
    upd_en  = clr_we | (|set_vec);
    db_d    = (db_q & ~clr_eff) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_q <= '0;
    end else if (upd_en) begin
      db_q <= db_d;
    end
  end

  // R2 R3 R6
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((db_q & $past(set_vec)) == $past(set_vec)));

  // R5
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((db_q & $past(clr_mask & ~set_vec)) == '0));

  // R8
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((db_q & $past(db_q)) == $past(db_q)));

  // R4
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((db_q & ~$past(db_q) & ~$past(set_vec)) == '0));

endmodule

// File: rtl/db_bit_decode.sv
module db_bit_decode #(
  parameter int N_IF  = 32,
  parameter int PAIRS = 8,
  localparam int IDX_W = $clog2(PAIRS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDX_W:0]  sel_bit,
  output logic [N_IF-1:0] cand_if,
  output logic            cand_is_recv
);
  localparam int BASE_CNT = N_IF / PAIRS;
  localparam int REM_CNT  = N_IF % PAIRS;

  logic [IDX_W-1:0] sel_idx;
  db_pkg::db_dir_e  sel_dir;

  assign sel_idx      = sel_bit[IDX_W-1:0];
  assign sel_dir      = db_pkg::db_dir_e'(sel_bit[IDX_W]);
  assign cand_is_recv = (sel_dir == db_pkg::DB_DIR_RECV);

  for (genvar i = 0; i < N_IF; i++) begin : g_cand
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(i % PAIRS);
    assign cand_if[i] = (sel_idx == SLOT);
  end

  // R10
  cand_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cand_if) == BASE_CNT + ((int'(sel_idx) < REM_CNT) ? 1 : 0)));

  // R9
  cand_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel_idx) < N_IF) |-> cand_if[sel_idx]);

endmodule

// File: rtl/doorbell_irq_mapper.sv
module doorbell_irq_mapper #(
  parameter int N_IF  = 32,
  parameter int PAIRS = 8,
  localparam int REG_W = 2 * PAIRS,
  localparam int SEL_W = $clog2(REG_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IF-1:0]  send_evt,
  input  logic [N_IF-1:0]  recv_evt,
  input  logic             clr_we,
  input  logic [REG_W-1:0] clr_mask,
  input  logic [SEL_W-1:0] sel_bit,
  output logic [REG_W-1:0] db_bits,
  output logic             irq,
  output logic [N_IF-1:0]  cand_if,
  output logic             cand_is_recv
);
  logic [1:0]       rst_sync;
  logic             rst_core_n;
  logic [PAIRS-1:0] send_hit;
  logic [PAIRS-1:0] recv_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync[1];

  db_event_fold #(.N_IF(N_IF), .PAIRS(PAIRS)) u_fold_send (
    .clk(clk), .rst_n(rst_core_n), .evt(send_evt), .hit(send_hit));

  db_event_fold #(.N_IF(N_IF), .PAIRS(PAIRS)) u_fold_recv (
    .clk(clk), .rst_n(rst_core_n), .evt(recv_evt), .hit(recv_hit));

  db_w1c_reg #(.W(REG_W)) u_reg (
    .clk(clk), .rst_n(rst_core_n), .set_vec({recv_hit, send_hit}),
    .clr_we(clr_we), .clr_mask(clr_mask), .db_q(db_bits));

  db_bit_decode #(.N_IF(N_IF), .PAIRS(PAIRS)) u_dec (
    .clk(clk), .rst_n(rst_core_n), .sel_bit(sel_bit),
    .cand_if(cand_if), .cand_is_recv(cand_is_recv));

  assign irq = |db_bits;

  // R7
  irq_fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(irq) |-> $past(clr_we));

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (irq && !clr_we) |=> irq);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_core_n |-> (!irq && db_bits == '0));

endmodule

// File: tb/tb_doorbell_irq_mapper.sv
module tb_doorbell_irq_mapper;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] send_evt = '0;
  logic [N-1:0] recv_evt = '0;
  logic        clr_we = 1'b0;
  logic [15:0] clr_mask = '0;
  logic [3:0]  sel_bit = '0;
  logic [15:0] db_bits;
  logic        irq;
  logic [N-1:0] cand_if;
  logic        cand_is_recv;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    live = 1'b0;
  bit    done = 1'b0;
  string tag = "R1";
  logic [15:0] model = '0;

  doorbell_irq_mapper dut (
    .clk(clk), .rst_n(rst_n), .send_evt(send_evt), .recv_evt(recv_evt),
    .clr_we(clr_we), .clr_mask(clr_mask), .sel_bit(sel_bit),
    .db_bits(db_bits), .irq(irq), .cand_if(cand_if), .cand_is_recv(cand_is_recv));

  always #4 clk = ~clk;

  task automatic chk(input string t, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  // behavioural reference: clear first, then events win
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model = '0;
    else begin
      if (clr_we) model = model & ~clr_mask;
      for (int i = 0; i < N; i++) begin
        if (send_evt[i]) model[i % 8] = 1'b1;
        if (recv_evt[i]) model[8 + (i % 8)] = 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (live) begin
      logic [N-1:0] exp_c;
      for (int i = 0; i < N; i++) exp_c[i] = ((i % 8) == int'(sel_bit[2:0]));
      chk({tag, " reg"}, 64'(db_bits), 64'(model));
      chk("R7 irq", 64'(irq), 64'(model != 0));
      chk("R9 cand", 64'(cand_if), 64'(exp_c));
      chk("R9 dir", 64'(cand_is_recv), 64'(sel_bit[3]));
    end
  end

  task automatic tick(input logic [N-1:0] s, input logic [N-1:0] r,
                      input logic we, input logic [15:0] m);
    send_evt = s; recv_evt = r; clr_we = we; clr_mask = m;
    @(posedge clk);
    @(negedge clk);
    #1;
    send_evt = '0; recv_evt = '0; clr_we = 1'b0; clr_mask = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 reg", 64'(db_bits), 64'h0);
    chk("R1 irq", 64'(irq), 64'h0);
    live = 1'b1;
    #1;

    tag = "R2";
    tick(32'h0000_0008, '0, 1'b0, '0);
    chk("R2 if3 send", 64'(db_bits), 64'h0008);
    tag = "R3";
    tick('0, 32'h0000_2000, 1'b0, '0);
    chk("R3 if13 recv", 64'(db_bits), 64'h2008);
    tag = "R4";
    tick(32'h0800_0800, '0, 1'b0, '0);
    chk("R4 shared bit", 64'(db_bits), 64'h2008);
    tick('0, '0, 1'b0, '0);
    chk("R4 sticky", 64'(db_bits), 64'h2008);
    tag = "R5";
    tick('0, '0, 1'b1, 16'h0008);
    chk("R5 w1c", 64'(db_bits), 64'h2000);
    chk("R7 still high", 64'(irq), 64'h1);
    tag = "R8";
    tick('0, '0, 1'b0, 16'hFFFF);
    chk("R8 mask ignored", 64'(db_bits), 64'h2000);
    tag = "R6";
    tick('0, 32'h0000_0020, 1'b1, 16'h2000);
    chk("R6 set wins", 64'(db_bits), 64'h2000);
    tag = "R7";
    tick('0, '0, 1'b1, 16'h2000);
    chk("R7 irq low", 64'(irq), 64'h0);
    tick(32'h8000_0000, '0, 1'b0, '0);
    chk("R2 if31 send", 64'(db_bits), 64'h0080);
    tick('0, '0, 1'b1, 16'hFFFF);

    tag = "R9";
    for (int s = 0; s < 16; s++) begin
      sel_bit = 4'(s);
      @(negedge clk);
      chk("R10 count", 64'($countones(cand_if)), 64'd4);
      chk("R9 dir bit", 64'(cand_is_recv), 64'(s >= 8));
      #1;
    end

    tag = "R5";
    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] s_v, r_v;
      s_v = ($urandom % 4 == 0) ? (N'(1) << ($urandom % N)) : '0;
      r_v = ($urandom % 4 == 0) ? (N'(1) << ($urandom % N)) : '0;
      sel_bit = 4'($urandom % 16);
      tick(s_v, r_v, ($urandom % 3 == 0), 16'($urandom));
    end
    tick('0, '0, 1'b1, 16'hFFFF);
    chk("R7 drained", 64'(irq), 64'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule